// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects an on-chip master to an external asynchronous static RAM holding 128K bytes. The master raises a one-cycle request carrying a 17-bit address, a write flag and a write byte. The controller then drives the memory pins through a full read or write cycle and answers with a one-cycle ready pulse. For a read, the fetched byte comes back at the same time as the pulse.

The memory has two chip enables of opposite polarity, an active-low output enable, an active-low write enable and a bidirectional byte bus. The bus is split here into a driven value, a sampled value and a drive enable. The length of each phase is a whole number of clock cycles. These counts are computed at elaboration from the clock period and from the nanosecond limits of the chosen speed grade. The fast grade uses access 55, output-enable access 25, write pulse 40, data setup 25, address-to-end-of-write 40 and cycle 55. The slow grade uses 70, 35, 50, 30, 60 and 70. Each limit is rounded up to whole cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, the memory is deselected: mem_ce_n_o=1, mem_ce_o=0, mem_oe_n_o=1, mem_we_n_o=1, mem_dq_oe_o=0, ready_o=0. The two enables always switch together.
- R2: A read holds the memory selected, with mem_oe_n_o=0, mem_we_n_o=1 and the address steady, for RD_CYC = ceil(max(access, output-enable access, cycle)/period) cycles. The data is sampled on the last of these cycles. At 10 ns with the fast grade, RD_CYC is 6.
- R3: ready_o is high for exactly one cycle, in the first idle cycle after a phase ends. After a read, rdata_o carries the byte sampled from the memory, and it keeps that value until the next read completes.
- R4: A write holds mem_we_n_o=0 with the memory selected for WP_CYC = ceil(max(write pulse, data setup, address-to-end, enable-to-end)/period) cycles. During that time the write byte is driven on mem_dq_o with mem_dq_oe_o=1 and the address is held steady. The fast grade at 10 ns gives 4.
- R5: After the write pulse, a recovery phase keeps the memory selected, the write enable high and the data and address held. It lasts max(1, ceil(cycle/period) - WP_CYC) cycles, which is 2 for the fast grade at 10 ns.
- R6: mem_oe_n_o stays high for the whole of every write. The controller never drives the data bus while output enable is low, and write enable and output enable are never low together.
- R7: When a write is requested in the ready cycle of a read, one extra deselected clock is inserted before the write pulse begins.
- R8: A request is accepted only in an idle cycle. A request raised while a phase is in progress is ignored: it produces no ready pulse and writes nothing.
- R9: Counted from the first rising edge at which the request is high, ready_o is seen RD_CYC+1 cycles later for a read, and WP_CYC+REC_CYC+1 cycles later for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| mem_addr_o | output | 17 | Memory address bus |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_ce_o | output | 1 | Chip enable, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data sampled from the memory |

## Verification
All pin outputs come from registers that update on the accept edge. The bench therefore counts cycles from that edge and samples on the falling edge in between. From that edge, read pins are seen 1 cycle later and the ready pulse RD_CYC+1 cycles later. The write-enable rise is seen WP_CYC+1 cycles later, and the write ready pulse WP_CYC+REC_CYC+1 cycles later, or one more after a read. The memory model in the bench returns wrong data until the real nanosecond access limits have passed since the address and output-enable changes. It also measures pulse width, data setup and address validity when write enable rises. A phase that is too short therefore shows up as a failed check even when the cycle counts look right.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WWAIT, ST_WPULSE, ST_WREC} state_e;

  function automatic int ceil_cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int grade_ns(input bit fast, input int fast_ns, input int slow_ns);
    return fast ? fast_ns : slow_ns;
  endfunction
endpackage

// File: rtl/sram_phase_cnt.sv
`timescale 1ns/1ps
module sram_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  AST_CNT_LOAD_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1); // R2
endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int RD_CYC  = 6,
  parameter int WP_CYC  = 4,
  parameter int REC_CYC = 2,
  parameter int CW      = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_n_o,
  output logic          mem_ce_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i,
  input  logic          cnt_last_i,
  output logic          cnt_load_o,
  output logic [CW-1:0] cnt_val_o
);
  state_e state_q, state_d;
  logic   last_rd_q;
  logic   sel_q, oe_n_q, we_n_q, dq_oe_q, ready_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic   accept, phase_end;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign phase_end = cnt_last_i && (state_q == ST_RD || state_q == ST_WREC);

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        cnt_load_o = 1'b1;
        if (!wr_i) begin
          state_d   = ST_RD;
          cnt_val_o = CW'(RD_CYC - 1);
        end else if (last_rd_q) begin
          state_d   = ST_WWAIT;
        end else begin
          state_d   = ST_WPULSE;
          cnt_val_o = CW'(WP_CYC - 1);
        end
      end
      ST_RD:  if (cnt_last_i) state_d = ST_IDLE;
      ST_WWAIT: if (cnt_last_i) begin
        state_d    = ST_WPULSE;
        cnt_load_o = 1'b1;
        cnt_val_o  = CW'(WP_CYC - 1);
      end
      ST_WPULSE: if (cnt_last_i) begin
        state_d    = ST_WREC;
        cnt_load_o = 1'b1;
        cnt_val_o  = CW'(REC_CYC - 1);
      end
      ST_WREC: if (cnt_last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
      sel_q     <= 1'b0;
      oe_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
      ready_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= (state_d == ST_RD) || (state_d == ST_WPULSE) || (state_d == ST_WREC);
      oe_n_q  <= (state_d != ST_RD);
      we_n_q  <= (state_d != ST_WPULSE);
      dq_oe_q <= (state_d == ST_WPULSE) || (state_d == ST_WREC);
      ready_q <= phase_end;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (state_q == ST_RD && cnt_last_i) rdata_q <= mem_dq_i;
      // flag lives exactly through the ready cycle after a read
      if (state_q == ST_RD && cnt_last_i) last_rd_q <= 1'b1;
      else if (state_q == ST_IDLE)        last_rd_q <= 1'b0;
    end
  end

  assign ready_o     = ready_q;
  assign rdata_o     = rdata_q;
  assign mem_addr_o  = addr_q;
  assign mem_ce_n_o  = !sel_q;
  assign mem_ce_o    = sel_q;
  assign mem_oe_n_o  = oe_n_q;
  assign mem_we_n_o  = we_n_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;

  // checker-only pulse width counter
  int unsigned we_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      we_low_q <= 0;
    else if (!we_n_q) we_low_q <= we_low_q + 1;
    else              we_low_q <= 0;
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o); // R6
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_n_o && !mem_oe_n_o)); // R6
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R3
  AST_READY_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce_n_o && !mem_ce_o)); // R1
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ce_o && $past(mem_ce_o)) |-> $stable(mem_addr_o)); // R2
  AST_WE_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> we_low_q >= WP_CYC); // R4
  AST_REC_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> mem_ce_o); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RD) |=> $stable(rdata_o)); // R3
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 17,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter bit FAST_GRADE    = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_n_o,
  output logic          mem_ce_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int T_ACC_NS = grade_ns(FAST_GRADE, 55, 70);
  localparam int T_OEA_NS = grade_ns(FAST_GRADE, 25, 35);
  localparam int T_CYC_NS = grade_ns(FAST_GRADE, 55, 70);
  localparam int T_WP_NS  = grade_ns(FAST_GRADE, 40, 50);
  localparam int T_DS_NS  = grade_ns(FAST_GRADE, 25, 30);
  localparam int T_AE_NS  = grade_ns(FAST_GRADE, 40, 60);
  localparam int T_CE_NS  = grade_ns(FAST_GRADE, 40, 60);

  localparam int RD_CYC  = ceil_cyc(max2(max2(T_ACC_NS, T_OEA_NS), T_CYC_NS), CLK_PERIOD_NS);
  localparam int WP_CYC  = ceil_cyc(max2(max2(T_WP_NS, T_DS_NS), max2(T_AE_NS, T_CE_NS)),
                                    CLK_PERIOD_NS);
  localparam int WC_CYC  = ceil_cyc(T_CYC_NS, CLK_PERIOD_NS);
  localparam int REC_CYC = max2(1, WC_CYC - WP_CYC);
  localparam int CW      = $clog2(max2(max2(RD_CYC, WP_CYC), REC_CYC) + 1);

  logic          cnt_last, cnt_load;
  logic [CW-1:0] cnt_val;

  sram_phase_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .last_o     (cnt_last)
  );

  sram_ctrl_seq #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .CW(CW)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_ce_o    (mem_ce_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .mem_dq_i    (mem_dq_i),
    .cnt_last_i  (cnt_last),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val)
  );

  AST_ENABLES_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_n_o == !mem_ce_o); // R1
endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int CLK_NS = 10;
  localparam int AW = 17;
  localparam int DW = 8;
  // fast-grade limits, ns
  localparam int TAA = 55, TOE = 25, TRC = 55, TWP = 40, TDW = 25, TAW = 40, TWC = 55;

  function automatic int cdiv(input int a, input int b); return (a + b - 1) / b; endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction

  localparam int EXP_RD  = cdiv(mx(mx(TAA, TOE), TRC), CLK_NS);
  localparam int EXP_WP  = cdiv(mx(mx(TWP, TDW), TAW), CLK_NS);
  localparam int EXP_REC = mx(1, cdiv(TWC, CLK_NS) - EXP_WP);

  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready;
  logic [DW-1:0] rdata;
  logic [AW-1:0] m_addr;
  logic m_ce_n, m_ce, m_oe_n, m_we_n, m_dq_oe;
  logic [DW-1:0] m_dq_o;
  logic [DW-1:0] m_dq_i = 8'h5A;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rdata_o(rdata), .mem_addr_o(m_addr), .mem_ce_n_o(m_ce_n),
    .mem_ce_o(m_ce), .mem_oe_n_o(m_oe_n), .mem_we_n_o(m_we_n), .mem_dq_o(m_dq_o),
    .mem_dq_oe_o(m_dq_oe), .mem_dq_i(m_dq_i)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- memory model with ns timing ----------------
  logic [7:0] mem [256];
  longint t_addr = 0, t_oe = 0, t_sel = 0, t_wef = 0, t_dat = 0;
  logic sel;
  assign sel = !m_ce_n && m_ce;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  always @(m_addr) t_addr = $time;
  always @(m_dq_o) t_dat = $time;
  always @(negedge m_oe_n) t_oe = $time;
  always @(negedge m_we_n) t_wef = $time;
  always @(posedge sel) t_sel = $time;
  always @(negedge sel) if (rst_n)
    chk($time - t_sel >= TRC, "R2 cycle length ns", $time - t_sel, TRC);
  always @(posedge m_we_n) if (sel && rst_n) begin
    chk($time - t_wef >= TWP, "R4 write pulse ns", $time - t_wef, TWP);
    chk($time - t_dat >= TDW, "R4 data setup ns", $time - t_dat, TDW);
    chk($time - t_addr >= TAW, "R4 address valid ns", $time - t_addr, TAW);
    chk(m_dq_oe, "R4 data driven at end of write", m_dq_oe, 1);
    mem[m_addr[7:0]] = m_dq_o;
  end
  always begin
    #1;
    if (sel && !m_oe_n && m_we_n) begin
      if ($time - t_addr >= TAA && $time - t_oe >= TOE && $time - t_sel >= TAA)
        m_dq_i = mem[m_addr[7:0]];
      else
        m_dq_i = ~mem[m_addr[7:0]];
      if (m_dq_oe) chk(0, "R6 bus contention", 1, 0);
    end else m_dq_i = 8'h5A;
  end

  // ---------------- stimulus ----------------
  function automatic logic [AW-1:0] a_of(input int i); return AW'(i * 515); endfunction
  function automatic logic [DW-1:0] d_of(input int i); return DW'(i * 37 + 11); endfunction

  // called on a falling edge; returns on the falling edge where ready is seen
  task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit pin_chk, output int lat);
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk); req = 0; lat = 1;
    while (!ready && lat < 100) begin
      if (pin_chk && lat == 1) begin
        chk(sel && m_addr == a, "R2 R4 selected with address", m_addr, a);
        if (w) begin
          chk(!m_we_n && m_oe_n && m_dq_oe && m_dq_o == d, "R4 R6 write pins",
              {m_we_n, m_oe_n, m_dq_oe}, 3'b011);
        end else begin
          chk(!m_oe_n && m_we_n && !m_dq_oe, "R2 read pins", {m_we_n, m_oe_n, m_dq_oe}, 3'b100);
        end
      end
      if (pin_chk && w && lat == EXP_WP + 1)
        chk(m_we_n && sel && m_dq_oe && m_dq_o == d, "R5 recovery pins",
            {m_we_n, sel, m_dq_oe}, 3'b111);
      if (pin_chk && !w && lat == EXP_RD)
        chk(sel && !m_oe_n, "R2 still reading", sel, 1);
      @(negedge clk); lat++;
    end
    if (lat >= 100) chk(0, "R9 no ready", lat, 0);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(m_ce_n && !m_ce && m_oe_n && m_we_n && !m_dq_oe && !ready, "R1 reset pins",
        {m_ce_n, m_ce, m_oe_n, m_we_n, m_dq_oe, ready}, 6'b101100);
    rst_n = 1;
    @(negedge clk);
    chk(m_ce_n && !m_ce && !ready, "R1 idle after reset", {m_ce_n, m_ce}, 2'b10);

    for (int i = 0; i < 256; i++) begin
      do_op(1, a_of(i), d_of(i), i < 4, lat);
      chk(lat == EXP_WP + EXP_REC + 1, "R9 write latency", lat, EXP_WP + EXP_REC + 1);
      chk(m_ce_n && !m_ce && !m_dq_oe, "R1 R3 deselected in ready cycle", m_ce, 0);
    end
    for (int i = 255; i >= 0; i--) begin
      do_op(0, a_of(i), 8'h00, i > 251, lat);
      chk(lat == EXP_RD + 1, "R9 read latency", lat, EXP_RD + 1);
      chk(rdata == d_of(i), "R2 R3 read data", rdata, d_of(i));
    end

    // turnaround: write in the ready cycle of a read
    do_op(0, a_of(5), 8'h00, 0, lat);
    chk(rdata == d_of(5), "R3 read before turnaround", rdata, d_of(5));
    do_op(1, a_of(5), 8'h3C, 0, lat);
    chk(lat == EXP_WP + EXP_REC + 2, "R7 turnaround latency", lat, EXP_WP + EXP_REC + 2);
    chk(rdata == d_of(5), "R3 rdata held over write", rdata, d_of(5));
    do_op(0, a_of(5), 8'h00, 0, lat);
    chk(lat == EXP_RD + 1, "R9 read after write", lat, EXP_RD + 1);
    chk(rdata == 8'h3C, "R2 read after write data", rdata, 8'h3C);
    do_op(0, a_of(6), 8'h00, 0, lat);
    chk(lat == EXP_RD + 1, "R7 no gap read after read", lat, EXP_RD + 1);
    chk(rdata == d_of(6), "R2 back to back read data", rdata, d_of(6));

    // request during a busy phase is ignored
    req = 1; wr = 1; addr = a_of(9); wdata = 8'h77;
    @(negedge clk); req = 0;
    @(negedge clk);
    req = 1; wr = 1; addr = a_of(10); wdata = 8'hEE;
    @(negedge clk); req = 0;
    lat = 0;
    while (!ready && lat < 100) begin @(negedge clk); lat++; end
    chk(ready, "R8 first op completes", ready, 1);
    begin
      int extra = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (ready) extra++; end
      chk(extra == 0, "R8 no ready for busy request", extra, 0);
    end
    do_op(0, a_of(10), 8'h00, 0, lat);
    chk(rdata == d_of(10), "R8 busy write discarded", rdata, d_of(10));
    do_op(0, a_of(9), 8'h00, 0, lat);
    chk(rdata == 8'h77, "R8 accepted write stored", rdata, 8'h77);

    repeat (3) @(negedge clk);
    chk(m_ce_n && !m_ce && m_oe_n && m_we_n && !ready, "R1 idle at end",
        {m_ce_n, m_ce, m_oe_n, m_we_n}, 4'b1011);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule